// File: doc/BRIEF.md
# Coincident-Current Core Plane

This block is a cycle-level, synthesizable model of one bit plane of a magnetic store built from a grid of one-bit cells. Each cell sits where one column drive line (X) meets one row drive line (Y). Each drive line carries its own direction bit, either toward one or toward zero. A cell changes state only when both of its lines are driven in the same direction during the same cycle. A cell that sees only one driven line is half-selected and keeps its contents, just like a cell on no driven line.

The plane has one shared line that works either as the sense output or as the inhibit input. A role input chooses which. Reading is a clear operation: driving a cell toward zero empties it, and the plane reports a one-cycle sense pulse only if the cell held a one. Writing is a set operation, and it is held back when the inhibit current is applied in inhibit role. Drive patterns that select more than one X or more than one Y line are rejected with an error flag, and so are misuses of the inhibit input. A rejected drive changes no cell. Contents stay put for as long as no full select arrives.

Top module: `core_plane`

## Requirements
- R1: When `rst_n` is low at a clock edge, every cell becomes 0 and both `sense` and `drive_err` go low at that edge.
- R2: A full select with both direction bits at 1 (toward one), no error, and no active inhibit in inhibit role sets the selected cell to 1.
- R3: A full select with both direction bits at 0 (toward zero) clears the selected cell. If the cell held 1 and `role_inhibit` is 0, `sense` is high for exactly the cycle after the drive edge.
- R4: Clearing a cell that already holds 0 produces no sense pulse. A second clear of the same cell after a pulse therefore shows `sense` low.
- R5: A cell whose X line or Y line alone is driven, or which is on no driven line, keeps its value.
- R6: When the two driven lines carry different direction bits, no cell changes.
- R7: With `role_inhibit`=1 and `inhibit`=1, a toward-one full select leaves the selected cell unchanged.
- R8: With `role_inhibit`=1, a toward-zero full select clears the cell but `sense` stays low.
- R9: More than one bit set in `x_drv` or in `y_drv` sets `drive_err` in the next cycle, changes no cell and gives no sense pulse.
- R10: `inhibit`=1 while `role_inhibit`=0 sets `drive_err` in the next cycle and changes no cell.
- R11: `inhibit`=1 during a toward-zero full select sets `drive_err` in the next cycle and leaves the cell unchanged.
- R12: Stored values persist across any number of cycles with no full select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, clears all cells |
| x_drv | input | NX | X drive lines, at most one expected high |
| x_dir | input | NX | Per X line direction, 1 = toward one |
| y_drv | input | NY | Y drive lines, at most one expected high |
| y_dir | input | NY | Per Y line direction, 1 = toward one |
| role_inhibit | input | 1 | Shared line role: 0 = sense, 1 = inhibit |
| inhibit | input | 1 | Inhibit current request on the shared line |
| sense | output | 1 | Registered pulse, cell flipped from 1 to 0 |
| drive_err | output | 1 | Registered flag for an illegal drive combination |

## Verification
The bench goes after half-selected cells. A design that decoded each line on its own would disturb a whole row or column, and the final read sweep would find stray ones or lost ones. It also clears the same cell twice and clears cells in inhibit role. A design without destructive reads would pulse twice, and one that ignored the role would pulse when it should not. Multi-line drives, drives whose directions disagree and misplaced inhibits are each followed by a read of the targeted cell, so a design that let a rejected drive through is caught by a changed value rather than by the error flag alone.

// File: rtl/core_plane_pkg.sv
// Package: shared types for the core plane model.
// Assumes: nothing beyond IEEE 1800-2017.
package core_plane_pkg;

    // Operation resolved from one cycle of drive inputs
    typedef enum logic [1:0] {
        OP_IDLE        = 2'd0,  // no full select, or rejected drive
        OP_CLEAR       = 2'd1,  // toward zero on the selected cell
        OP_SET         = 2'd2,  // toward one, not inhibited
        OP_SET_BLOCKED = 2'd3   // toward one, held back by inhibit
    } plane_op_t;

endpackage

// File: rtl/core_drive_decode.sv
// Module: core_drive_decode
// Turns the X/Y drive lines, their directions and the shared line controls
// into one plane operation plus an error flag for the cycle.
// Assumes: a full select needs exactly one X and one Y line; purely combinational.
module core_drive_decode
    import core_plane_pkg::*;
#(
    parameter int NX = 16,
    parameter int NY = 16
) (
    input  logic [NX-1:0] x_drv,
    input  logic [NX-1:0] x_dir,
    input  logic [NY-1:0] y_drv,
    input  logic [NY-1:0] y_dir,
    input  logic          role_inhibit,
    input  logic          inhibit,
    output plane_op_t     op,
    output logic          err
);

    logic x_one, y_one, x_many, y_many;
    logic x_way, y_way, full_sel, agree, inh_bad;

    // Classify the drive pattern and take the direction of the driven lines
    always_comb begin
        x_one    = $onehot(x_drv);
        y_one    = $onehot(y_drv);
        x_many   = !$onehot0(x_drv);
        y_many   = !$onehot0(y_drv);
        x_way    = |(x_drv & x_dir);
        y_way    = |(y_drv & y_dir);
        full_sel = x_one && y_one;
        agree    = (x_way == y_way);
        inh_bad  = inhibit && (!role_inhibit || (full_sel && agree && !x_way));
        err      = x_many || y_many || inh_bad;
    end

    // Resolve the operation the cell array must apply
    always_comb begin
        op = OP_IDLE;
        if (!err && full_sel && agree) begin
            if (x_way) begin
                op = (role_inhibit && inhibit) ? OP_SET_BLOCKED : OP_SET;
            end else begin
                op = OP_CLEAR;
            end
        end
    end

endmodule

// File: rtl/core_cell_array.sv
// Module: core_cell_array
// The grid of storage cells. A cell updates only at the crossing of its X and
// Y lines under a set or clear operation. Also reports the old value of the
// crossed cell.
// Assumes: op is OP_IDLE whenever the drive lines are not one-hot.
module core_cell_array
    import core_plane_pkg::*;
#(
    parameter int NX = 16,
    parameter int NY = 16,
    localparam int NCELL = NX * NY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NX-1:0]    x_drv,
    input  logic [NY-1:0]    y_drv,
    input  plane_op_t        op,
    output logic [NCELL-1:0] cells,
    output logic             was_one
);

    logic [NCELL-1:0] hit;

    for (genvar gy = 0; gy < NY; gy++) begin : g_row
        for (genvar gx = 0; gx < NX; gx++) begin : g_col
            localparam int IDX = gy * NX + gx;

            // Coincidence: this cell sees both of its lines driven
            assign hit[IDX] = x_drv[gx] & y_drv[gy];

            // Cell state: set or clear only under a full select
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cells[IDX] <= 1'b0;
                end else if (hit[IDX] && op == OP_SET) begin
                    cells[IDX] <= 1'b1;
                end else if (hit[IDX] && op == OP_CLEAR) begin
                    cells[IDX] <= 1'b0;
                end
            end
        end
    end

    // Old value of the crossed cell, valid under a full select
    always_comb was_one = |(cells & hit);

endmodule

// File: rtl/core_sense_unit.sv
// Module: core_sense_unit
// Registers the sense pulse and the error flag. A pulse needs a clear of a
// cell that held 1 while the shared line is in sense role.
// Assumes: the decoder never issues OP_CLEAR in an error cycle.
module core_sense_unit
    import core_plane_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  plane_op_t op,
    input  logic      was_one,
    input  logic      role_inhibit,
    input  logic      err_in,
    output logic      sense,
    output logic      drive_err
);

    // Register the one-cycle sense pulse and the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense     <= 1'b0;
            drive_err <= 1'b0;
        end else begin
            sense     <= (op == OP_CLEAR) && was_one && !role_inhibit;
            drive_err <= err_in;
        end
    end

endmodule

// File: rtl/core_plane.sv
// Module: core_plane (top)
// One bit plane of a coincident-current store: decode, cell grid and
// sense/error registers.
// Assumes: synchronous active-low reset; NX, NY >= 2.
module core_plane
    import core_plane_pkg::*;
#(
    parameter int NX = 16,
    parameter int NY = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NX-1:0] x_drv,
    input  logic [NX-1:0] x_dir,
    input  logic [NY-1:0] y_drv,
    input  logic [NY-1:0] y_dir,
    input  logic          role_inhibit,
    input  logic          inhibit,
    output logic          sense,
    output logic          drive_err
);

    localparam int NCELL = NX * NY;

    plane_op_t        op;
    logic             err_c;
    logic             was_one;
    logic [NCELL-1:0] cell_q;

    core_drive_decode #(.NX(NX), .NY(NY)) decode_i (
        .x_drv        (x_drv),
        .x_dir        (x_dir),
        .y_drv        (y_drv),
        .y_dir        (y_dir),
        .role_inhibit (role_inhibit),
        .inhibit      (inhibit),
        .op           (op),
        .err          (err_c)
    );

    core_cell_array #(.NX(NX), .NY(NY)) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_drv   (x_drv),
        .y_drv   (y_drv),
        .op      (op),
        .cells   (cell_q),
        .was_one (was_one)
    );

    core_sense_unit sense_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .was_one      (was_one),
        .role_inhibit (role_inhibit),
        .err_in       (err_c),
        .sense        (sense),
        .drive_err    (drive_err)
    );

endmodule

// File: rtl/core_plane_chk.sv
// Module: core_plane_chk
// Temporal checks on the plane ports and cell state, bound into core_plane.
// Assumes: the same clock and synchronous reset as the plane.
module core_plane_chk #(
    parameter int NX = 16,
    parameter int NY = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NX-1:0]      x_drv,
    input logic [NX-1:0]      x_dir,
    input logic [NY-1:0]      y_drv,
    input logic [NY-1:0]      y_dir,
    input logic               role_inhibit,
    input logic               inhibit,
    input logic               sense,
    input logic               drive_err,
    input logic [NX*NY-1:0]   cells
);

    // R9: several X or several Y lines flag an error
    a_r9_multi_err: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot0(x_drv) || !$onehot0(y_drv)) |=> drive_err);

    // R9: a rejected multi-line drive changes no cell
    a_r9_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!$onehot0(x_drv) || !$onehot0(y_drv)) |=> $stable(cells));

    // R10: inhibit in sense role is an error and changes no cell
    a_r10_inh_role_err: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !role_inhibit) |=> (drive_err && $stable(cells)));

    // R5: with no full select possible, the grid holds
    a_r5_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (x_drv == '0 || y_drv == '0) |=> $stable(cells));

    // R3: a pulse follows only a clean toward-zero full select in sense role
    a_r3_sense_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sense |-> ($onehot($past(x_drv)) && $onehot($past(y_drv)) &&
                   (($past(x_drv) & $past(x_dir)) == '0) &&
                   (($past(y_drv) & $past(y_dir)) == '0) &&
                   !$past(role_inhibit) && !$past(inhibit)));

    // R8: inhibit role never yields a pulse
    a_r8_no_sense_inh: assert property (@(posedge clk) disable iff (!rst_n)
        role_inhibit |=> !sense);

    // R3: a pulse lasts one cycle per drive and never comes with an error
    a_r3_no_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sense |-> !drive_err);

endmodule

bind core_plane core_plane_chk #(.NX(NX), .NY(NY)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .x_drv        (x_drv),
    .x_dir        (x_dir),
    .y_drv        (y_drv),
    .y_dir        (y_dir),
    .role_inhibit (role_inhibit),
    .inhibit      (inhibit),
    .sense        (sense),
    .drive_err    (drive_err),
    .cells        (cell_q)
);

// File: tb/core_plane_tb.sv
`timescale 1ns/1ps
// Bench for core_plane: directed corner cases, then seeded random drives,
// all checked against a bench model of the grid.
module core_plane_tb_top;

    localparam int NX = 16;
    localparam int NY = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NX-1:0] x_drv = '0;
    logic [NX-1:0] x_dir = '0;
    logic [NY-1:0] y_drv = '0;
    logic [NY-1:0] y_dir = '0;
    logic          role_inhibit = 1'b0;
    logic          inhibit = 1'b0;
    logic          sense;
    logic          drive_err;

    int total = 0;
    int bad = 0;
    bit model [NY][NX];
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_plane #(.NX(NX), .NY(NY)) dut_i (
        .clk(clk), .rst_n(rst_n), .x_drv(x_drv), .x_dir(x_dir),
        .y_drv(y_drv), .y_dir(y_dir), .role_inhibit(role_inhibit),
        .inhibit(inhibit), .sense(sense), .drive_err(drive_err)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Apply one cycle of drives, then compare sense and drive_err with the model
    task automatic step(input logic [NX-1:0] xd, input logic [NX-1:0] xr,
                        input logic [NY-1:0] yd, input logic [NY-1:0] yr,
                        input logic m, input logic inh, input string lbl);
        int xc, yc, xi, yi;
        bit xw, yw, full, e, es;
        string tag;
        xc = $countones(xd); yc = $countones(yd);
        xi = 0; yi = 0; xw = 0; yw = 0;
        for (int i = 0; i < NX; i++) if (xd[i]) begin xi = i; xw = xr[i]; end
        for (int j = 0; j < NY; j++) if (yd[j]) begin yi = j; yw = yr[j]; end
        full = (xc == 1) && (yc == 1);
        es = 0;
        tag = lbl;
        if (xc > 1 || yc > 1) begin e = 1; if (tag == "") tag = "R9"; end
        else if (inh && !m) begin e = 1; if (tag == "") tag = "R10"; end
        else if (inh && full && xw == yw && !xw) begin e = 1; if (tag == "") tag = "R11"; end
        else e = 0;
        if (tag == "") tag = (full && xw == yw) ? (xw ? "R2" : "R3") : "R5";
        x_drv = xd; x_dir = xr; y_drv = yd; y_dir = yr; role_inhibit = m; inhibit = inh;
        @(negedge clk);
        if (!e && full && xw == yw) begin
            if (xw) begin
                if (!(m && inh)) model[yi][xi] = 1;
            end else begin
                es = model[yi][xi] && !m;
                model[yi][xi] = 0;
            end
        end
        check(tag, "sense", sense, es);
        check(tag, "drive_err", drive_err, e);
    endtask

    function automatic logic [NX-1:0] xb(input int i);
        return NX'(1) << i;
    endfunction
    function automatic logic [NY-1:0] yb(input int j);
        return NY'(1) << j;
    endfunction

    task automatic setc(input int i, input int j);
        step(xb(i), '1, yb(j), '1, 1'b0, 1'b0, "R2");
    endtask

    // Destructive read: the expected pulse comes from the model
    task automatic readc(input int i, input int j, input string lbl);
        step(xb(i), '0, yb(j), '0, 1'b0, 1'b0, lbl);
    endtask

    task automatic sweep(input string lbl);
        for (int j = 0; j < NY; j++)
            for (int i = 0; i < NX; i++) readc(i, j, lbl);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk); @(negedge clk);
        check("R1", "sense in reset", sense, 1'b0);
        check("R1", "drive_err in reset", drive_err, 1'b0);
        rst_n = 1'b1;
        // R1: every cell reads 0 after reset
        sweep("R1");

        // R2/R3/R4: set, destructive read, second read empty
        setc(3, 5);
        readc(3, 5, "R3");
        readc(3, 5, "R4");

        // R5: half selects on X only, Y only, then read back
        setc(2, 2);
        step(xb(2), '0, '0, '0, 1'b0, 1'b0, "R5");
        step('0, '0, yb(2), '0, 1'b0, 1'b0, "R5");
        step(xb(2), '1, '0, '1, 1'b0, 1'b0, "R5");
        readc(2, 2, "R5");
        readc(2, 3, "R5");

        // R6: disagreeing directions on a set cell and on an empty cell
        setc(4, 4);
        step(xb(4), '0, yb(4), '1, 1'b0, 1'b0, "R6");
        step(xb(5), '1, yb(5), '0, 1'b0, 1'b0, "R6");
        readc(4, 4, "R6");
        readc(5, 5, "R6");

        // R7: inhibited set leaves 0
        step(xb(1), '1, yb(1), '1, 1'b1, 1'b1, "R7");
        readc(1, 1, "R7");

        // R8: clear in inhibit role gives no pulse, cell is emptied
        setc(6, 6);
        step(xb(6), '0, yb(6), '0, 1'b1, 1'b0, "R8");
        readc(6, 6, "R8");

        // R9: two X lines through a set cell
        setc(8, 8);
        step(xb(8) | xb(9), '0, yb(8), '0, 1'b0, 1'b0, "R9");
        step(xb(8), '0, yb(8) | yb(0), '0, 1'b0, 1'b0, "R9");
        readc(8, 8, "R9");

        // R10: inhibit while in sense role
        setc(9, 9);
        step(xb(9), '0, yb(9), '0, 1'b0, 1'b1, "R10");
        readc(9, 9, "R10");

        // R11: inhibit during a toward-zero full select
        setc(10, 10);
        step(xb(10), '0, yb(10), '0, 1'b1, 1'b1, "R11");
        readc(10, 10, "R11");

        // R12: contents persist over idle cycles
        setc(15, 15);
        for (int k = 0; k < 60; k++) step('0, '0, '0, '0, 1'b0, 1'b0, "R12");
        readc(15, 15, "R12");

        // Random drives mixing legal and illegal patterns
        for (int n = 0; n < 3000; n++) begin
            logic [NX-1:0] xd;
            logic [NY-1:0] yd;
            int pick;
            pick = $urandom_range(9);
            xd = (pick == 0) ? '0 : xb($urandom_range(NX-1));
            yd = (pick == 1) ? '0 : yb($urandom_range(NY-1));
            if (pick == 2) xd = xd | xb($urandom_range(NX-1));
            if (pick == 3) yd = yd | yb($urandom_range(NY-1));
            step(xd, NX'($urandom()), yd, NY'($urandom()),
                 1'($urandom_range(1)), ($urandom_range(7) == 0), "");
        end

        // R12: final sweep compares every cell with the model
        sweep("R12");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule